// File: doc/BRIEF.md
# Processor status flag update unit

This block keeps the four arithmetic condition flags of an 8-bit accumulator processor: negative (N), overflow (V), zero (Z) and carry (C). They are held in one 4-bit register. On every rising clock edge the register either holds its contents or takes an update picked by one of five command strobes. Each kind of update loads its own subset of flags. Some flags come from the ALU's freshly computed carry, overflow and zero results, some come from fixed bits of the data bus, and the flags the update does not touch keep their values.

The flags are driven out continuously. A branch-decision output picks one flag with a 3-bit branch selector, taken from opcode bits 7..5, and reports whether that flag matches the polarity the selector requests. The microcode asserts at most one strobe in normal use. When several are asserted together, a fixed priority settles which update applies.

The update is organised as a small decoded state per cycle. `UPD_HOLD` is the idle state with no strobe. The other states are `UPD_NZ`, `UPD_NZC`, `UPD_NZCV`, `UPD_BITTEST` and `UPD_PULL`. The priority arbiter moves into one of these each cycle, and the register applies the chosen update at the edge. Each named state returns to `UPD_HOLD` on the next cycle unless a strobe is still asserted.

Top module: `psr_flag_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears N, V, Z and C to 0, whatever the strobes are.
- R2: With no strobe asserted, all four flags keep their values across the edge, whatever the data bus and ALU inputs are.
- R3: `cmd_nz` alone sets Z from `alu_z` and N from data-bus bit 7 at the next edge, and keeps V and C.
- R4: `cmd_nzc` alone sets Z from `alu_z`, C from `alu_c` and N from data-bus bit 7, and keeps V.
- R5: `cmd_nzcv` alone sets Z, C and V from `alu_z`, `alu_c` and `alu_v`, and N from data-bus bit 7.
- R6: `cmd_pull` sets all four flags from the data bus: N from bit 7, V from bit 6, Z from bit 1 and C from bit 0.
- R7: `cmd_bittest` sets N from data-bus bit 7 and V from data-bus bit 6, and keeps Z and C.
- R8: When several strobes are asserted at once, the priority from highest to lowest is `cmd_pull`, `cmd_bittest`, `cmd_nzcv`, `cmd_nzc`, `cmd_nz`.
- R9: `br_sel[2:1]` picks the flag: 00 selects N, 01 selects V, 10 selects C and 11 selects Z. `branch_taken` is 1 exactly when the selected flag equals `br_sel[0]`. It follows `br_sel` combinationally and follows the flags as they change at the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 8 | Data bus value |
| alu_c | input | 1 | New carry from the ALU |
| alu_v | input | 1 | New overflow from the ALU |
| alu_z | input | 1 | New zero from the ALU |
| cmd_nz | input | 1 | Strobe: update N and Z |
| cmd_nzc | input | 1 | Strobe: update N, Z and C |
| cmd_nzcv | input | 1 | Strobe: update N, Z, C and V |
| cmd_pull | input | 1 | Strobe: load all flags from the bus |
| cmd_bittest | input | 1 | Strobe: load N and V from the bus |
| br_sel | input | 3 | Branch selector (opcode bits 7..5) |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| branch_taken | output | 1 | Selected flag matches requested polarity |

## Verification
Every flag update and every reset is due exactly one rising edge after the cycle in which the strobe or `rst` is presented. `branch_taken` is due in the same cycle as a selector change, and one edge after a flag change. The driver changes inputs on the falling edge and queues the expected flags and branch value for the next rising edge. The monitor pops one item 2 ns after each rising edge and compares it against the outputs. Because the selector stays unchanged until the following falling edge, one sample covers both the registered flags and the combinational branch output.

// File: rtl/psr_pkg.sv
package psr_pkg;

    // Decoded update kind: one per cycle, chosen by the strobe arbiter.
    typedef enum logic [2:0] {
        UPD_HOLD    = 3'd0,
        UPD_NZ      = 3'd1,
        UPD_NZC     = 3'd2,
        UPD_NZCV    = 3'd3,
        UPD_BITTEST = 3'd4,
        UPD_PULL    = 3'd5
    } upd_kind_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/psr_cmd_arbiter.sv
module psr_cmd_arbiter
    import psr_pkg::*;
(
    input  logic      cmd_nz,
    input  logic      cmd_nzc,
    input  logic      cmd_nzcv,
    input  logic      cmd_pull,
    input  logic      cmd_bittest,
    output upd_kind_e kind
);

    // Fixed priority: pull > bit test > nzcv > nzc > nz.
    always_comb begin
        if (cmd_pull)         kind = UPD_PULL;
        else if (cmd_bittest) kind = UPD_BITTEST;
        else if (cmd_nzcv)    kind = UPD_NZCV;
        else if (cmd_nzc)     kind = UPD_NZC;
        else if (cmd_nz)      kind = UPD_NZ;
        else                  kind = UPD_HOLD;
    end

endmodule

// File: rtl/psr_flag_reg.sv
module psr_flag_reg
    import psr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_POS  = DATA_W - 1,
    parameter int V_POS  = DATA_W - 2,
    parameter int Z_POS  = 1,
    parameter int C_POS  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  upd_kind_e         kind,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              alu_c,
    input  logic              alu_v,
    input  logic              alu_z,
    output flags_t            q
);

    flags_t nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    // Next-value selection per update kind
    always_comb begin
        nxt = q;
        unique case (kind)
            UPD_HOLD: nxt = q;
            UPD_NZ: begin
                nxt.n = bus_data[N_POS];
                nxt.z = alu_z;
            end
            UPD_NZC: begin
                nxt.n = bus_data[N_POS];
                nxt.z = alu_z;
                nxt.c = alu_c;
            end
            UPD_NZCV: begin
                nxt.n = bus_data[N_POS];
                nxt.z = alu_z;
                nxt.c = alu_c;
                nxt.v = alu_v;
            end
            UPD_BITTEST: begin
                nxt.n = bus_data[N_POS];
                nxt.v = bus_data[V_POS];
            end
            UPD_PULL: begin
                nxt.n = bus_data[N_POS];
                nxt.v = bus_data[V_POS];
                nxt.z = bus_data[Z_POS];
                nxt.c = bus_data[C_POS];
            end
            default: nxt = q;
        endcase
    end

    // R1: reset clears the register at the following edge
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R2: the idle state keeps every flag
    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (kind == UPD_HOLD) |=> $stable(q));

    // R7: bit test keeps Z and C
    assert_bittest_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (kind == UPD_BITTEST) |=> ($stable(q.z) && $stable(q.c)));

endmodule

// File: rtl/psr_branch_sel.sv
module psr_branch_sel
    import psr_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  flags_t           flags,
    input  logic [SEL_W-1:0] sel,
    output logic             taken
);

    logic picked;

    // Top two selector bits pick the flag, the low bit gives the polarity.
    always_comb begin
        unique case (sel[SEL_W-1 -: 2])
            2'b00:   picked = flags.n;
            2'b01:   picked = flags.v;
            2'b10:   picked = flags.c;
            2'b11:   picked = flags.z;
            default: picked = 1'b0;
        endcase
        taken = (picked == sel[0]);
    end

endmodule

// File: rtl/psr_flag_unit.sv
module psr_flag_unit
    import psr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              alu_c,
    input  logic              alu_v,
    input  logic              alu_z,
    input  logic              cmd_nz,
    input  logic              cmd_nzc,
    input  logic              cmd_nzcv,
    input  logic              cmd_pull,
    input  logic              cmd_bittest,
    input  logic [SEL_W-1:0]  br_sel,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_z,
    output logic              flag_c,
    output logic              branch_taken
);

    localparam int N_POS = DATA_W - 1;
    localparam int V_POS = DATA_W - 2;

    upd_kind_e kind;
    flags_t    flags;

    psr_cmd_arbiter u_arb (
        .cmd_nz      (cmd_nz),
        .cmd_nzc     (cmd_nzc),
        .cmd_nzcv    (cmd_nzcv),
        .cmd_pull    (cmd_pull),
        .cmd_bittest (cmd_bittest),
        .kind        (kind)
    );

    psr_flag_reg #(
        .DATA_W (DATA_W),
        .N_POS  (N_POS),
        .V_POS  (V_POS),
        .Z_POS  (1),
        .C_POS  (0)
    ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .bus_data (bus_data),
        .alu_c    (alu_c),
        .alu_v    (alu_v),
        .alu_z    (alu_z),
        .q        (flags)
    );

    psr_branch_sel #(.SEL_W(SEL_W)) u_br (
        .flags (flags),
        .sel   (br_sel),
        .taken (branch_taken)
    );

    assign flag_n = flags.n;
    assign flag_v = flags.v;
    assign flag_z = flags.z;
    assign flag_c = flags.c;

    // R6 and R8: a pull wins over every other strobe and copies bus bits 7,6,1,0
    assert_pull_load_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_pull |=> (flag_n == $past(bus_data[N_POS]) && flag_v == $past(bus_data[V_POS])
                   && flag_z == $past(bus_data[1]) && flag_c == $past(bus_data[0])));

    // R3: a lone nz strobe keeps V and C
    assert_nz_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_nz && !cmd_nzc && !cmd_nzcv && !cmd_pull && !cmd_bittest)
        |=> ($stable(flag_v) && $stable(flag_c) && flag_z == $past(alu_z)));

    // R5: nzcv without higher strobes takes all ALU flags
    assert_nzcv_load_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_nzcv && !cmd_pull && !cmd_bittest)
        |=> (flag_v == $past(alu_v) && flag_c == $past(alu_c) && flag_z == $past(alu_z)));

    // R9: selector 000 reports N clear
    assert_branch_nclear_R9: assert property (@(posedge clk) disable iff (rst)
        (br_sel == 3'b000) |-> (branch_taken == !flag_n));

endmodule

// File: tb/psr_flag_unit_tb_top.sv
module psr_flag_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_data = '0;
    logic       alu_c = 0, alu_v = 0, alu_z = 0;
    logic       cmd_nz = 0, cmd_nzc = 0, cmd_nzcv = 0, cmd_pull = 0, cmd_bittest = 0;
    logic [2:0] br_sel = '0;
    logic       flag_n, flag_v, flag_z, flag_c, branch_taken;

    always #5 clk = ~clk;

    psr_flag_unit dut_i (
        .clk(clk), .rst(rst), .bus_data(bus_data),
        .alu_c(alu_c), .alu_v(alu_v), .alu_z(alu_z),
        .cmd_nz(cmd_nz), .cmd_nzc(cmd_nzc), .cmd_nzcv(cmd_nzcv),
        .cmd_pull(cmd_pull), .cmd_bittest(cmd_bittest), .br_sel(br_sel),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .branch_taken(branch_taken)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [3:0] q_flags[$];   // {n,v,z,c}
    logic       q_br[$];
    string      q_req[$];
    logic [3:0] mdl = 4'b0000;

    function automatic logic br_model(logic [3:0] f, logic [2:0] s);
        logic p;
        case (s[2:1])
            2'b00:   p = f[3];
            2'b01:   p = f[2];
            2'b10:   p = f[0];
            default: p = f[1];
        endcase
        return p == s[0];
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic drive(input logic r, input logic [4:0] cmds, input logic [7:0] bus,
                         input logic az, input logic av, input logic ac,
                         input logic [2:0] sel, input string req);
        // cmds = {pull, bittest, nzcv, nzc, nz}
        @(negedge clk);
        rst = r; bus_data = bus; alu_z = az; alu_v = av; alu_c = ac; br_sel = sel;
        {cmd_pull, cmd_bittest, cmd_nzcv, cmd_nzc, cmd_nz} = cmds;
        if (r)            mdl = 4'b0000;
        else if (cmds[4]) mdl = {bus[7], bus[6], bus[1], bus[0]};
        else if (cmds[3]) mdl = {bus[7], bus[6], mdl[1], mdl[0]};
        else if (cmds[2]) mdl = {bus[7], av, az, ac};
        else if (cmds[1]) mdl = {bus[7], mdl[2], az, ac};
        else if (cmds[0]) mdl = {bus[7], mdl[2], az, mdl[0]};
        q_flags.push_back(mdl);
        q_br.push_back(br_model(mdl, sel));
        q_req.push_back(req);
    endtask

    // Monitor: compares one queued item 2 ns after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_flags.size() > 0) begin
                logic [3:0] ef;
                logic       eb;
                string      rq;
                ef = q_flags.pop_front();
                eb = q_br.pop_front();
                rq = q_req.pop_front();
                n_checks++;
                if ({flag_n, flag_v, flag_z, flag_c} !== ef || branch_taken !== eb) begin
                    n_fail++;
                    $display("FAIL %s: nvzc=%b br=%b expected nvzc=%b br=%b",
                             rq, {flag_n, flag_v, flag_z, flag_c}, branch_taken, ef, eb);
                end
            end
        end
    end

    initial begin
        // R1: reset state
        drive(1, 5'b00000, 8'hFF, 1, 1, 1, 3'b000, "R1");
        drive(1, 5'b10000, 8'hFF, 1, 1, 1, 3'b001, "R1");
        // R6: pull loads bits 7,6,1,0
        drive(0, 5'b10000, 8'hC3, 0, 0, 0, 3'b001, "R6");
        drive(0, 5'b10000, 8'h41, 1, 1, 0, 3'b011, "R6");
        drive(0, 5'b10000, 8'hC3, 0, 0, 0, 3'b111, "R6");
        // R2: hold with changing bus and ALU inputs
        drive(0, 5'b00000, 8'h00, 0, 0, 0, 3'b101, "R2");
        drive(0, 5'b00000, 8'h3C, 1, 0, 1, 3'b010, "R2");
        // R3: nz
        drive(0, 5'b00001, 8'h00, 0, 0, 0, 3'b110, "R3");
        drive(0, 5'b00001, 8'h80, 1, 0, 0, 3'b000, "R3");
        // R4: nzc
        drive(0, 5'b00010, 8'h00, 0, 0, 0, 3'b100, "R4");
        drive(0, 5'b00010, 8'h80, 1, 0, 1, 3'b101, "R4");
        // R5: nzcv
        drive(0, 5'b00100, 8'h00, 0, 0, 1, 3'b010, "R5");
        drive(0, 5'b00100, 8'h7F, 1, 1, 0, 3'b011, "R5");
        // R7: bit test ignores ALU values, keeps Z and C
        drive(0, 5'b01000, 8'h40, 0, 0, 1, 3'b110, "R7");
        drive(0, 5'b01000, 8'h83, 1, 1, 0, 3'b100, "R7");
        // R8: simultaneous strobes
        drive(0, 5'b11111, 8'h02, 1, 1, 1, 3'b000, "R8");
        drive(0, 5'b01111, 8'hC0, 0, 0, 1, 3'b010, "R8");
        drive(0, 5'b00111, 8'h00, 0, 0, 0, 3'b100, "R8");
        drive(0, 5'b00011, 8'h80, 1, 1, 1, 3'b110, "R8");
        // R9: selector sweep over two flag patterns
        drive(0, 5'b10000, 8'h81, 0, 0, 0, 3'b000, "R9");
        for (int s = 0; s < 8; s++) drive(0, 5'b00000, 8'h00, 0, 0, 0, s[2:0], "R9");
        drive(0, 5'b10000, 8'h42, 0, 0, 0, 3'b000, "R9");
        for (int s = 0; s < 8; s++) drive(0, 5'b00000, 8'hFF, 1, 1, 1, s[2:0], "R9");
        // R1: reset beats a pull mid-run
        drive(1, 5'b10000, 8'hFF, 1, 1, 1, 3'b110, "R1");
        drive(0, 5'b00000, 8'h00, 0, 0, 0, 3'b000, "R1");
        @(negedge clk);
        {cmd_pull, cmd_bittest, cmd_nzcv, cmd_nzc, cmd_nz} = '0;
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule